// File: doc/BRIEF.md
# Paged PHY register window

This block is the register file of a small physical-layer device with three ports. A host reaches it through a 4-bit address and a plain synchronous read/write strobe pair. The lower eight addresses always reach fixed base registers. The upper eight addresses form a window whose contents depend on a page number and a port number. Both numbers are held in the last base register.

Three pages are defined. The status page shows eight read-only bytes for the chosen port, taken straight from input pins. The identification page shows constants set by parameters, whatever port is chosen. The user page holds eight bytes of read/write storage that every port value shares. Any other page, and the status page with an out-of-range port, reads as zero and ignores writes. Read data is registered and holds between reads.

Top module: `phy_regwin`

## Requirements
- R1: Reset (active-low `rst_n`) clears read data, base registers 0x0 to 0x6, the select register 0x7 and all eight user-page bytes to 0x00.
- R2: Base registers 0x0 to 0x6 are read/write bytes. Read data appears on `rdata` one clock after the cycle in which `rd_en` is high, and keeps its value while `rd_en` is low.
- R3: Register 0x7 holds the page number in bits [7:5] and the port number in bits [3:0]. Bit 4 is reserved: it ignores writes and reads as 0.
- R4: With page 0 and port p in 0 to 2, window address 0x8+r returns byte `port_status[(p*8+r)*8 +: 8]`.
- R5: With page 0 and a port number of 3 or more, window reads return 0x00. Window writes on page 0 change nothing for any port.
- R6: With page 1, window address 0x8+k returns byte k of the identification sequence for any port number. Bytes 0 to 2 are `VENDOR_ID`, most significant byte first. Bytes 3 to 5 are `PRODUCT_ID`, most significant byte first. Bytes 6 and 7 are 0x00. Writes on page 1 have no effect.
- R7: With page 7, window address 0x8+r reads and writes user byte r. The port number plays no part in this.
- R8: With page 2 to 6, window reads return 0x00 and window writes change no storage.
- R9: A write to 0x7 governs a window access made in the very next cycle.
- R10: When read and write hit the same location in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` with `wdata` |
| addr | input | AW (4) | Register address |
| wdata | input | DW (8) | Write data |
| port_status | input | NPORTS*8*DW (192) | Status bytes, eight per port, port 0 in the low bits |
| rdata | output | DW (8) | Registered read data |

## Verification
Every read result is due exactly one clock after its strobe. The bench raises the strobe on a falling edge and samples `rdata` at the next falling edge, half a cycle after the edge that loads it. A select write is followed at once, in the next cycle, by window reads. So each page and port sweep checks R9 with no idle gap in between. The hold behaviour is checked by sampling `rdata` again after several idle cycles. The same-cycle read/write case is checked by sampling in the cycle after the combined strobe, and then once more with a plain read.

// File: rtl/phy_regwin_pkg.sv
package phy_regwin_pkg;

    typedef enum logic [2:0] {
        BANK_BASE,
        BANK_CTL,
        BANK_STAT,
        BANK_ID,
        BANK_USER,
        BANK_NONE
    } bank_e;

    localparam int unsigned PG_STAT = 0;
    localparam int unsigned PG_ID   = 1;
    localparam int unsigned PG_USER = 7;

endpackage

// File: rtl/phy_regwin_decode.sv
module phy_regwin_decode
    import phy_regwin_pkg::*;
#(
    parameter int unsigned AW     = 4,
    parameter int unsigned IW     = 3,
    parameter int unsigned PAGE_W = 3,
    parameter int unsigned PORT_W = 4,
    parameter int unsigned NPORTS = 3
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PORT_W-1:0] port_i,
    output bank_e             bank_o,
    output logic [IW-1:0]     idx_o
);

    always_comb begin
        idx_o = addr_i[IW-1:0];
        if (!addr_i[AW-1]) begin
            bank_o = (&addr_i[IW-1:0]) ? BANK_CTL : BANK_BASE;
        end else if (page_i == PAGE_W'(PG_STAT)) begin
            // the port number only matters on the status page
            bank_o = (port_i < PORT_W'(NPORTS)) ? BANK_STAT : BANK_NONE;
        end else if (page_i == PAGE_W'(PG_ID)) begin
            bank_o = BANK_ID;
        end else if (page_i == PAGE_W'(PG_USER)) begin
            bank_o = BANK_USER;
        end else begin
            bank_o = BANK_NONE;
        end
    end

endmodule

// File: rtl/phy_regwin_id.sv
module phy_regwin_id #(
    parameter int unsigned DW       = 8,
    parameter int unsigned IW       = 3,
    parameter int unsigned ID_BYTES = 3,
    parameter logic [ID_BYTES*DW-1:0] VENDOR_ID  = '0,
    parameter logic [ID_BYTES*DW-1:0] PRODUCT_ID = '0
) (
    input  logic [IW-1:0] idx_i,
    output logic [DW-1:0] id_o
);

    localparam int unsigned NREG = 1 << IW;

    logic [DW-1:0] rom [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_rom
        if (k < ID_BYTES) begin : g_vendor
            assign rom[k] = VENDOR_ID[(ID_BYTES-1-k)*DW +: DW];
        end else if (k < 2*ID_BYTES) begin : g_product
            assign rom[k] = PRODUCT_ID[(2*ID_BYTES-1-k)*DW +: DW];
        end else begin : g_blank
            assign rom[k] = '0;
        end
    end

    assign id_o = rom[idx_i];

endmodule

// File: rtl/phy_regwin_statmux.sv
module phy_regwin_statmux #(
    parameter int unsigned DW     = 8,
    parameter int unsigned IW     = 3,
    parameter int unsigned NPORTS = 3,
    parameter int unsigned PORT_W = 4
) (
    input  logic [NPORTS*(1<<IW)*DW-1:0] stat_i,
    input  logic [PORT_W-1:0]            port_i,
    input  logic [IW-1:0]                idx_i,
    output logic [DW-1:0]                stat_o
);

    localparam int unsigned NREG = 1 << IW;
    localparam int unsigned NENT = NPORTS * NREG;

    logic [NENT-1:0][DW-1:0] ent;
    assign ent = stat_i;

    always_comb begin
        stat_o = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (port_i == PORT_W'(p)) begin
                stat_o = ent[p*NREG + int'(idx_i)];
            end
        end
    end

endmodule

// File: rtl/phy_regwin.sv
module phy_regwin
    import phy_regwin_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 4,
    parameter int unsigned NPORTS   = 3,
    parameter int unsigned PAGE_W   = 3,
    parameter int unsigned PORT_W   = 4,
    parameter int unsigned ID_BYTES = 3,
    parameter logic [ID_BYTES*DW-1:0] VENDOR_ID  = 24'h5A3C01,
    parameter logic [ID_BYTES*DW-1:0] PRODUCT_ID = 24'h0417B2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     addr,
    input  logic [DW-1:0]                     wdata,
    input  logic [NPORTS*(2**(AW-1))*DW-1:0]  port_status,
    output logic [DW-1:0]                     rdata
);

    localparam int unsigned IW   = AW - 1;
    localparam int unsigned NREG = 1 << IW;
    localparam logic [DW-1:0] PAGE_MASK = DW'(((1 << PAGE_W) - 1) << (DW - PAGE_W));
    localparam logic [DW-1:0] PORT_MASK = DW'((1 << PORT_W) - 1);
    localparam logic [DW-1:0] CTL_MASK  = PAGE_MASK | PORT_MASK;

    typedef struct packed {
        logic [NREG-2:0][DW-1:0] base;
        logic [DW-1:0]           ctl;
        logic [NREG-1:0][DW-1:0] user;
        logic [DW-1:0]           rdata;
    } state_t;

    state_t st_d, st_q;

    logic [PAGE_W-1:0] win_page;
    logic [PORT_W-1:0] win_port;
    bank_e             bank;
    logic [IW-1:0]     idx;
    logic [DW-1:0]     stat_byte;
    logic [DW-1:0]     id_byte;
    logic [DW-1:0]     rd_val;

    assign win_page = st_q.ctl[DW-1 -: PAGE_W];
    assign win_port = st_q.ctl[PORT_W-1:0];

    phy_regwin_decode #(
        .AW(AW), .IW(IW), .PAGE_W(PAGE_W), .PORT_W(PORT_W), .NPORTS(NPORTS)
    ) u_decode (
        .addr_i(addr), .page_i(win_page), .port_i(win_port),
        .bank_o(bank), .idx_o(idx)
    );

    phy_regwin_statmux #(
        .DW(DW), .IW(IW), .NPORTS(NPORTS), .PORT_W(PORT_W)
    ) u_statmux (
        .stat_i(port_status), .port_i(win_port), .idx_i(idx), .stat_o(stat_byte)
    );

    phy_regwin_id #(
        .DW(DW), .IW(IW), .ID_BYTES(ID_BYTES),
        .VENDOR_ID(VENDOR_ID), .PRODUCT_ID(PRODUCT_ID)
    ) u_id (
        .idx_i(idx), .id_o(id_byte)
    );

    always_comb begin
        st_d = st_q;

        case (bank)
            BANK_BASE: rd_val = st_q.base[idx];
            BANK_CTL:  rd_val = st_q.ctl;
            BANK_STAT: rd_val = stat_byte;
            BANK_ID:   rd_val = id_byte;
            BANK_USER: rd_val = st_q.user[idx];
            default:   rd_val = '0;
        endcase

        // read samples the pre-write contents
        if (rd_en) begin
            st_d.rdata = rd_val;
        end

        if (wr_en) begin
            case (bank)
                BANK_BASE: st_d.base[idx] = wdata;
                BANK_CTL:  st_d.ctl       = wdata & CTL_MASK;
                BANK_USER: st_d.user[idx] = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/phy_regwin_chk.sv
module phy_regwin_chk
    import phy_regwin_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 4,
    parameter int unsigned NPORTS   = 3,
    parameter int unsigned PAGE_W   = 3,
    parameter int unsigned PORT_W   = 4,
    parameter int unsigned ID_BYTES = 3,
    parameter logic [ID_BYTES*DW-1:0] VENDOR_ID = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     rdata,
    input logic [PAGE_W-1:0] page,
    input logic [PORT_W-1:0] port
);

    localparam logic [AW-1:0] CTL_ADDR = AW'((1 << (AW-1)) - 1);
    localparam logic [AW-1:0] WIN0     = AW'(1 << (AW-1));

    logic undef_page;
    assign undef_page = (page != PAGE_W'(PG_STAT)) && (page != PAGE_W'(PG_ID))
                     && (page != PAGE_W'(PG_USER));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> rdata == '0);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_ctl_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTL_ADDR) |=> rdata[DW-PAGE_W-1:PORT_W] == '0);

    p_badport_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[AW-1] && page == PAGE_W'(PG_STAT) && port >= PORT_W'(NPORTS))
        |=> rdata == '0);

    p_id_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == WIN0 && page == PAGE_W'(PG_ID))
        |=> rdata == VENDOR_ID[ID_BYTES*DW-1 -: DW]);

    p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[AW-1] && undef_page) |=> rdata == '0);

endmodule

bind phy_regwin phy_regwin_chk #(
    .DW(DW), .AW(AW), .NPORTS(NPORTS), .PAGE_W(PAGE_W), .PORT_W(PORT_W),
    .ID_BYTES(ID_BYTES), .VENDOR_ID(VENDOR_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
    .page(win_page), .port(win_port)
);

// File: tb/phy_regwin_tb.sv
module phy_regwin_tb;

    localparam logic [23:0] VID = 24'h5A3C01;
    localparam logic [23:0] PID = 24'h0417B2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rd_en, wr_en;
    logic [3:0]   addr;
    logic [7:0]   wdata;
    logic [191:0] port_status;
    logic [7:0]   rdata;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] user_model [8];

    always #5 clk = ~clk;

    phy_regwin #(.VENDOR_ID(VID), .PRODUCT_ID(PID)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .port_status(port_status), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_val(int p, int r, int seed);
        return 8'(p*37 + r*11 + seed);
    endfunction

    function automatic logic [7:0] id_val(int k);
        if (k < 3) return VID[(2-k)*8 +: 8];
        if (k < 6) return PID[(5-k)*8 +: 8];
        return 8'h00;
    endfunction

    task automatic load_status(input int seed);
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < 8; r++)
                port_status[(p*8+r)*8 +: 8] = stat_val(p, r, seed);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic sel(input int page, input int port);
        wr(4'h7, {3'(page), 1'b0, 4'(port)});
    endtask

    function automatic logic [7:0] win_exp(int page, int port, int r, int seed);
        if (page == 0) return (port < 3) ? stat_val(port, r, seed) : 8'h00;
        if (page == 1) return id_val(r);
        if (page == 7) return user_model[r];
        return 8'h00;
    endfunction

    function automatic string win_tag(int page, int port);
        if (page == 0) return (port < 3) ? "R4 status" : "R5 bad port";
        if (page == 1) return "R6 id";
        if (page == 7) return "R7 user";
        return "R8 undefined page";
    endfunction

    task automatic sweep(input int seed);
        logic [7:0] d;
        for (int pg = 0; pg < 8; pg++) begin
            for (int pt = 0; pt < 16; pt++) begin
                sel(pg, pt);
                // first window read follows the select write directly (R9)
                for (int r = 0; r < 8; r++) begin
                    rd(4'(8 + r), d);
                    check(r == 0 ? {win_tag(pg, pt), " R9"} : win_tag(pg, pt),
                          d, win_exp(pg, pt, r, seed));
                end
                rd(4'h7, d);
                check("R3 select readback", d, {3'(pg), 1'b0, 4'(pt)});
            end
        end
    endtask

    initial begin
        int unsigned cnt;
        cnt = 0;
        while (cnt < 200000) begin
            @(posedge clk);
            cnt++;
        end
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] d, held;
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        port_status = '0;
        load_status(5);
        for (int r = 0; r < 8; r++) user_model[r] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            check("R1 base after reset", d, 8'h00);
        end
        sel(7, 0);
        for (int r = 0; r < 8; r++) begin
            rd(4'(8 + r), d);
            check("R1 user after reset", d, 8'h00);
        end

        // R2: base read/write
        for (int a = 0; a < 7; a++) wr(4'(a), 8'(a*17 + 1));
        for (int a = 0; a < 7; a++) begin
            rd(4'(a), d);
            check("R2 base readback", d, 8'(a*17 + 1));
        end
        held = d;
        repeat (4) @(negedge clk);
        check("R2 hold while idle", rdata, held);
        wr(4'h1, 8'hC3);
        check("R2 hold across write", rdata, held);

        // R10: read and write in the same cycle
        wr(4'h2, 8'h11);
        rd_en = 1'b1; wr_en = 1'b1; addr = 4'h2; wdata = 8'h22;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 read old value", rdata, 8'h11);
        rd(4'h2, d);
        check("R10 new value stored", d, 8'h22);

        // R3: reserved bit
        wr(4'h7, 8'hFF);
        rd(4'h7, d);
        check("R3 reserved bit zero", d, 8'hEF);

        // R7: fill user page with port 0
        sel(7, 0);
        for (int r = 0; r < 8; r++) begin
            wr(4'(8 + r), 8'(r*29 + 3));
            user_model[r] = 8'(r*29 + 3);
        end

        // R5, R6, R8: writes outside the user page change nothing
        sel(0, 1);
        for (int r = 0; r < 8; r++) wr(4'(8 + r), 8'hA5);
        sel(0, 9);
        for (int r = 0; r < 8; r++) wr(4'(8 + r), 8'hA5);
        sel(1, 0);
        for (int r = 0; r < 8; r++) wr(4'(8 + r), 8'hA5);
        for (int pg = 2; pg < 7; pg++) begin
            sel(pg, 2);
            for (int r = 0; r < 8; r++) wr(4'(8 + r), 8'h5A);
        end

        // R7: user bytes written under another port
        sel(7, 13);
        wr(4'hC, 8'h77);
        user_model[4] = 8'h77;

        sweep(5);
        load_status(91);
        sweep(91);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule